// File: doc/BRIEF.md
# Phased SPI Master Transaction Sequencer

This block is a SPI master that runs one transaction at a time. A transaction is built from up to four phases: a command field, an address field, a stretch of idle clocks, and a data field. Each phase has its own enable and its own length. The phases that are enabled and have a nonzero length run back to back under one chip-select assertion. The serial clock comes from the system clock through a programmable divider. The bus runs in SPI mode 0 and shifts most-significant bit first.

The data field works in one of two ways. In half-duplex mode the outgoing bits are sent first and the incoming bits are captured after them. In full-duplex mode both directions run together, and each direction keeps its own length. Each direction holds up to 512 bits. The user loads the configuration and the outgoing data on the input pins and pulses `start`. The block takes a copy of everything at that moment. When the transaction ends it raises `done` for one cycle, and the received bits are then available on `rx_data`.

Top module: `spi_phase_seq`

## Requirements
- R1: Phases run in this fixed order: command, address, idle clocks, data. A phase whose enable is 0 or whose length is 0 produces no SCLK cycles, whatever its other settings.
- R2: The command phase sends `cmd_len` (0..16) bits of `cmd_val` on MOSI. The first bit sent is `cmd_val[cmd_len-1]` and the last is `cmd_val[0]`.
- R3: The address phase sends `addr_len` (0..32) bits of `addr_val` on MOSI. The first bit sent is `addr_val[addr_len-1]` and the last is `addr_val[0]`.
- R4: The idle-clock phase lasts `dummy_len` (0..256) SCLK cycles. MOSI is held at 0 and MISO is not stored.
- R5: Half-duplex data (`full_duplex`=0) lasts `tx_len`+`rx_len` SCLK cycles. It first sends `tx_data[tx_len-1]` down to `tx_data[0]`, then holds MOSI at 0 for `rx_len` cycles while it captures MISO. The first captured bit lands in `rx_data[rx_len-1]` and the last in `rx_data[0]`. Bits above `rx_len-1` read 0.
- R6: Full-duplex data (`full_duplex`=1) lasts max(`tx_len`,`rx_len`) SCLK cycles. Sending starts in the same cycle as capture. MOSI is 0 once the outgoing bits are exhausted. Only the first `rx_len` MISO bits are stored, right-aligned as in R5.
- R7: SPI mode 0 applies. SCLK idles low. MOSI changes only while SCLK is low. MISO is sampled on each SCLK rising edge. Every SCLK high or low half lasts `clk_div`+1 system clock cycles.
- R8: CS_n falls in the cycle after `start` is accepted. The first SCLK rise comes `clk_div`+1 cycles after that fall. CS_n stays low through every SCLK edge of the transaction, and it rises `clk_div`+1 cycles after the last SCLK fall.
- R9: `busy` is high while CS_n is low. `done` is high for exactly one cycle, the cycle in which CS_n returns high.
- R10: A `start` that arrives while `busy` is high is ignored. Configuration inputs and `tx_data` are captured when `start` is accepted, so later changes to them have no effect on the running transaction.
- R11: If no phase would produce a clock, `done` pulses in the cycle after `start`. In that case SCLK never toggles, CS_n stays high and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, one cycle |
| clk_div | input | 8 | SCLK half period minus one, in system cycles |
| cmd_en | input | 1 | Command phase enable |
| cmd_len | input | 5 | Command length in bits |
| cmd_val | input | 16 | Command bits, right-aligned |
| addr_en | input | 1 | Address phase enable |
| addr_len | input | 6 | Address length in bits |
| addr_val | input | 32 | Address bits, right-aligned |
| dummy_en | input | 1 | Idle-clock phase enable |
| dummy_len | input | 9 | Idle-clock count |
| tx_en | input | 1 | Outgoing data enable |
| tx_len | input | 10 | Outgoing data length in bits |
| rx_en | input | 1 | Incoming data enable |
| rx_len | input | 10 | Incoming data length in bits |
| full_duplex | input | 1 | 1 runs send and receive together |
| tx_data | input | 512 | Outgoing bits, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rx_data | output | 512 | Captured bits, right-aligned |

## Verification
Two things can fall in the same cycle: the running transaction's own bit stream, and a fresh `start` carrying different configuration. To provoke this, the bench lets a transaction run for some cycles and then pulses `start` mid-flight. In the same moment it rewrites the command value, the lengths, the divider and the outgoing data on the input pins. The bench judges the result from the serial pins. It rebuilds the expected MOSI stream and SCLK edge count from the configuration that was applied at launch, and checks that timing and the received word also match that first configuration and not the rewritten one.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DUMMY = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_TRAIL = 2'd3
    } state_e;

    localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/spi_half_timer.sv
// Counts system cycles within one SCLK half period; tick marks its last cycle.
module spi_half_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == div);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_len_calc.sv
// Turns enables and raw lengths into the effective clock count of each phase.
module spi_len_calc
    import spi_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 11
) (
    input  logic                               cmd_en,
    input  logic [IDX_W-1:0]                   cmd_len,
    input  logic                               addr_en,
    input  logic [IDX_W-1:0]                   addr_len,
    input  logic                               dummy_en,
    input  logic [IDX_W-1:0]                   dummy_len,
    input  logic                               tx_en,
    input  logic [IDX_W-1:0]                   tx_len,
    input  logic                               rx_en,
    input  logic [IDX_W-1:0]                   rx_len,
    input  logic                               full_duplex,
    output logic [NUM_PHASES-1:0][IDX_W-1:0]   lens,
    output logic [IDX_W-1:0]                   tx_eff,
    output logic [IDX_W-1:0]                   rx_eff
);
    always_comb begin
        tx_eff = tx_en ? tx_len : '0;
        rx_eff = rx_en ? rx_len : '0;
        lens[PH_CMD]   = cmd_en   ? cmd_len   : '0;
        lens[PH_ADDR]  = addr_en  ? addr_len  : '0;
        lens[PH_DUMMY] = dummy_en ? dummy_len : '0;
        if (full_duplex) begin
            lens[PH_DATA] = (tx_eff > rx_eff) ? tx_eff : rx_eff;
        end else begin
            lens[PH_DATA] = tx_eff + rx_eff;
        end
    end
endmodule

// File: rtl/spi_phase_pick.sv
// Finds the lowest-numbered phase at or after 'from' with a nonzero length.
module spi_phase_pick
    import spi_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 11
) (
    input  logic [NUM_PHASES-1:0][IDX_W-1:0] lens,
    input  logic [2:0]                       from,
    output logic                             found,
    output phase_e                           pick
);
    always_comb begin
        found = 1'b0;
        pick  = PH_CMD;
        for (int p = NUM_PHASES - 1; p >= 0; p--) begin
            if ((3'(p) >= from) && (lens[p] != '0)) begin
                found = 1'b1;
                pick  = phase_e'(2'(p));
            end
        end
    end
endmodule

// File: rtl/spi_bit_mux.sv
// Selects the MOSI bit of the current position and flags positions that store MISO.
module spi_bit_mux
    import spi_seq_pkg::*;
#(
    parameter int unsigned CMD_W  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 512,
    parameter int unsigned IDX_W  = 11
) (
    input  logic              active,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  cmd_len,
    input  logic [IDX_W-1:0]  addr_len,
    input  logic [IDX_W-1:0]  tx_len,
    input  logic [IDX_W-1:0]  rx_len,
    input  logic              full_duplex,
    input  logic [CMD_W-1:0]  cmd_bits,
    input  logic [ADDR_W-1:0] addr_bits,
    input  logic [DATA_W-1:0] tx_bits,
    output logic              mosi_bit,
    output logic              capture
);
    logic [CMD_W-1:0]  cmd_sh;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              in_tx;

    always_comb begin
        cmd_sh   = cmd_bits  >> (cmd_len  - idx - 1'b1);
        addr_sh  = addr_bits >> (addr_len - idx - 1'b1);
        tx_sh    = tx_bits   >> (tx_len   - idx - 1'b1);
        in_tx    = (idx < tx_len);
        mosi_bit = 1'b0;
        capture  = 1'b0;
        if (active) begin
            unique case (phase)
                PH_CMD:   mosi_bit = cmd_sh[0];
                PH_ADDR:  mosi_bit = addr_sh[0];
                PH_DUMMY: mosi_bit = 1'b0;
                PH_DATA: begin
                    mosi_bit = in_tx ? tx_sh[0] : 1'b0;
                    if (full_duplex) begin
                        capture = (idx < rx_len);
                    end else begin
                        capture = !in_tx;
                    end
                end
                default: mosi_bit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
    import spi_seq_pkg::*;
#(
    parameter int unsigned CMD_W     = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DUMMY_MAX = 256,
    parameter int unsigned DATA_W    = 512,
    parameter int unsigned DIV_W     = 8,
    localparam int unsigned CL_W     = $clog2(CMD_W + 1),
    localparam int unsigned AL_W     = $clog2(ADDR_W + 1),
    localparam int unsigned DL_W     = $clog2(DUMMY_MAX + 1),
    localparam int unsigned XL_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_en,
    input  logic [CL_W-1:0]   cmd_len,
    input  logic [CMD_W-1:0]  cmd_val,
    input  logic              addr_en,
    input  logic [AL_W-1:0]   addr_len,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              dummy_en,
    input  logic [DL_W-1:0]   dummy_len,
    input  logic              tx_en,
    input  logic [XL_W-1:0]   tx_len,
    input  logic              rx_en,
    input  logic [XL_W-1:0]   rx_len,
    input  logic              full_duplex,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int unsigned IDX_W = $clog2(2 * DATA_W + DUMMY_MAX + CMD_W + ADDR_W + 1);

    typedef struct packed {
        state_e                            state;
        phase_e                            phase;
        logic [IDX_W-1:0]                  idx;
        logic [NUM_PHASES-1:0][IDX_W-1:0]  lens;
        logic [IDX_W-1:0]                  tx_len;
        logic [IDX_W-1:0]                  rx_len;
        logic                              fdx;
        logic [DIV_W-1:0]                  div;
        logic [CMD_W-1:0]                  cmd;
        logic [ADDR_W-1:0]                 addr;
        logic [DATA_W-1:0]                 tx;
        logic [DATA_W-1:0]                 rx;
        logic                              sclk;
        logic                              cs_n;
        logic                              busy;
        logic                              done;
    } seq_t;

    seq_t s_d, s_q;

    // Effective lengths of the configuration presented at the inputs.
    logic [NUM_PHASES-1:0][IDX_W-1:0] in_lens;
    logic [IDX_W-1:0]                 in_tx_eff, in_rx_eff;

    spi_len_calc #(.IDX_W(IDX_W)) u_len (
        .cmd_en     (cmd_en),
        .cmd_len    (IDX_W'(cmd_len)),
        .addr_en    (addr_en),
        .addr_len   (IDX_W'(addr_len)),
        .dummy_en   (dummy_en),
        .dummy_len  (IDX_W'(dummy_len)),
        .tx_en      (tx_en),
        .tx_len     (IDX_W'(tx_len)),
        .rx_en      (rx_en),
        .rx_len     (IDX_W'(rx_len)),
        .full_duplex(full_duplex),
        .lens       (in_lens),
        .tx_eff     (in_tx_eff),
        .rx_eff     (in_rx_eff)
    );

    // First live phase for a new launch.
    logic   first_found;
    phase_e first_phase;

    spi_phase_pick #(.IDX_W(IDX_W)) u_pick_first (
        .lens (in_lens),
        .from (3'd0),
        .found(first_found),
        .pick (first_phase)
    );

    // Next live phase after the one that is running.
    logic   next_found;
    phase_e next_phase;

    spi_phase_pick #(.IDX_W(IDX_W)) u_pick_next (
        .lens (s_q.lens),
        .from ({1'b0, s_q.phase} + 3'd1),
        .found(next_found),
        .pick (next_phase)
    );

    logic tick;

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.state != ST_IDLE),
        .div  (s_q.div),
        .tick (tick)
    );

    logic mosi_bit, capture;

    spi_bit_mux #(
        .CMD_W (CMD_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_mux (
        .active     (s_q.state != ST_IDLE),
        .phase      (s_q.phase),
        .idx        (s_q.idx),
        .cmd_len    (s_q.lens[PH_CMD]),
        .addr_len   (s_q.lens[PH_ADDR]),
        .tx_len     (s_q.tx_len),
        .rx_len     (s_q.rx_len),
        .full_duplex(s_q.fdx),
        .cmd_bits   (s_q.cmd),
        .addr_bits  (s_q.addr),
        .tx_bits    (s_q.tx),
        .mosi_bit   (mosi_bit),
        .capture    (capture)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.lens   = in_lens;
                    s_d.tx_len = in_tx_eff;
                    s_d.rx_len = in_rx_eff;
                    s_d.fdx    = full_duplex;
                    s_d.div    = clk_div;
                    s_d.cmd    = cmd_val;
                    s_d.addr   = addr_val;
                    s_d.tx     = tx_data;
                    s_d.rx     = '0;
                    s_d.idx    = '0;
                    s_d.phase  = first_phase;
                    if (first_found) begin
                        s_d.state = ST_LOW;
                        s_d.cs_n  = 1'b0;
                        s_d.busy  = 1'b1;
                    end else begin
                        s_d.done  = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    s_d.sclk  = 1'b1;
                    s_d.state = ST_HIGH;
                    if (capture) begin
                        s_d.rx = {s_q.rx[DATA_W-2:0], miso};
                    end
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    s_d.sclk = 1'b0;
                    if ((s_q.idx + 1'b1) < s_q.lens[s_q.phase]) begin
                        s_d.idx   = s_q.idx + 1'b1;
                        s_d.state = ST_LOW;
                    end else if (next_found) begin
                        s_d.idx   = '0;
                        s_d.phase = next_phase;
                        s_d.state = ST_LOW;
                    end else begin
                        s_d.state = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    s_d.cs_n  = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk    = s_q.sclk;
    assign cs_n    = s_q.cs_n;
    assign mosi    = mosi_bit;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rx_data = s_q.rx;
endmodule

// File: rtl/spi_phase_seq_chk.sv
module spi_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic done
);
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R7

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R8

    AST_CS_FALL_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start)); // R8

    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy)); // R9

    AST_QUIET_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (cs_n && !sclk)); // R11
endmodule

bind spi_phase_seq spi_phase_seq_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .sclk (sclk),
    .cs_n (cs_n),
    .mosi (mosi),
    .busy (busy),
    .done (done)
);

// File: tb/tb_spi_phase_seq.sv
`timescale 1ns/1ps
module tb_spi_phase_seq;
    localparam int DATA_W = 512;
    localparam int MAXB   = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        clk_div = '0;
    logic              cmd_en = 1'b0, addr_en = 1'b0, dummy_en = 1'b0;
    logic              tx_en = 1'b0, rx_en = 1'b0, full_duplex = 1'b0;
    logic [4:0]        cmd_len = '0;
    logic [15:0]       cmd_val = '0;
    logic [5:0]        addr_len = '0;
    logic [31:0]       addr_val = '0;
    logic [8:0]        dummy_len = '0;
    logic [9:0]        tx_len = '0, rx_len = '0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              miso;
    logic              sclk, cs_n, mosi, busy, done;
    logic [DATA_W-1:0] rx_data;

    always #2.5 clk = ~clk;

    spi_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
        .cmd_en(cmd_en), .cmd_len(cmd_len), .cmd_val(cmd_val),
        .addr_en(addr_en), .addr_len(addr_len), .addr_val(addr_val),
        .dummy_en(dummy_en), .dummy_len(dummy_len),
        .tx_en(tx_en), .tx_len(tx_len), .rx_en(rx_en), .rx_len(rx_len),
        .full_duplex(full_duplex), .tx_data(tx_data), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
        .rx_data(rx_data)
    );

    // Bench copy of the configuration used for expectations
    int                k_div, k_cl, k_al, k_dl, k_tl, k_rl;
    bit                k_ce, k_ae, k_de, k_te, k_re, k_fd;
    logic [15:0]       k_cmd;
    logic [31:0]       k_addr;
    logic [DATA_W-1:0] k_tx;

    int checks = 0;
    int failures = 0;

    // Slave-side monitor
    logic pat [0:MAXB-1];
    logic rec [0:MAXB-1];
    int   cyc = 0, rise_cnt = 0, cs_fall_cyc = 0, first_rise_cyc = 0;
    int   last_fall_cyc = 0, cs_rise_cyc = 0, last_edge_cyc = 0;
    int   done_cnt = 0, done_long = 0, cs_bad = 0, half_bad = 0;
    logic sclk_p = 1'b0, cs_p = 1'b1, done_p = 1'b0;

    assign miso = (rise_cnt < MAXB) ? pat[rise_cnt] : 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk != sclk_p) begin
            if (rise_cnt > 0 || !sclk) begin
                if (cyc - last_edge_cyc != k_div + 1) half_bad = half_bad + 1;
            end
            last_edge_cyc = cyc;
        end
        if (sclk && !sclk_p) begin
            if (rise_cnt < MAXB) rec[rise_cnt] = mosi;
            if (rise_cnt == 0) first_rise_cyc = cyc;
            if (cs_n) cs_bad = cs_bad + 1;
            rise_cnt = rise_cnt + 1;
        end
        if (!sclk && sclk_p) last_fall_cyc = cyc;
        if (!cs_n && cs_p) cs_fall_cyc = cyc;
        if (cs_n && !cs_p) cs_rise_cyc = cyc;
        if (done) done_cnt = done_cnt + 1;
        if (done && done_p) done_long = done_long + 1;
        sclk_p = sclk;
        cs_p   = cs_n;
        done_p = done;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_cfg();
        clk_div = 8'(k_div);
        cmd_en = k_ce;    cmd_len = 5'(k_cl);   cmd_val = k_cmd;
        addr_en = k_ae;   addr_len = 6'(k_al);  addr_val = k_addr;
        dummy_en = k_de;  dummy_len = 9'(k_dl);
        tx_en = k_te;     tx_len = 10'(k_tl);
        rx_en = k_re;     rx_len = 10'(k_rl);
        full_duplex = k_fd;
        tx_data = k_tx;
    endtask

    // Launch, wait for the end, and compare the serial stream and received word
    task automatic run_txn(input string tag, input bit poke);
        int ce, ae, de, te, re, dlen, total, n, off, mism, guard;
        logic exp_bit [0:MAXB-1];
        logic [DATA_W-1:0] erx;
        @(negedge clk);
        rise_cnt = 0; done_cnt = 0; done_long = 0; cs_bad = 0; half_bad = 0;
        apply_cfg();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (12) @(negedge clk);
            cmd_val = ~k_cmd; tx_data = ~k_tx; tx_len = 10'd3; cmd_len = 5'd2;
            clk_div = 8'(k_div + 2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 40000) begin
            @(negedge clk);
            guard = guard + 1;
        end
        chk(guard < 40000, {tag, " R9 done seen"}, guard, 0);
        repeat (3) @(negedge clk);

        ce = k_ce ? k_cl : 0;
        ae = k_ae ? k_al : 0;
        de = k_de ? k_dl : 0;
        te = k_te ? k_tl : 0;
        re = k_re ? k_rl : 0;
        dlen = k_fd ? ((te > re) ? te : re) : te + re;
        total = ce + ae + de + dlen;
        n = 0;
        for (int i = 0; i < ce; i++) begin exp_bit[n] = k_cmd[ce-1-i]; n++; end
        for (int i = 0; i < ae; i++) begin exp_bit[n] = k_addr[ae-1-i]; n++; end
        for (int i = 0; i < de; i++) begin exp_bit[n] = 1'b0; n++; end
        for (int i = 0; i < dlen; i++) begin
            exp_bit[n] = (i < te) ? k_tx[te-1-i] : 1'b0;
            n++;
        end
        mism = 0;
        for (int i = 0; i < total && i < MAXB; i++) begin
            if (rec[i] !== exp_bit[i]) mism++;
        end
        off = ce + ae + de + (k_fd ? 0 : te);
        erx = '0;
        for (int i = 0; i < re; i++) erx[re-1-i] = pat[off+i];

        chk(rise_cnt == total, {tag, " R1 sclk rise count"}, rise_cnt, total);
        chk(mism == 0, {tag, " R2 R3 R4 mosi stream mismatches"}, mism, 0);
        chk(rx_data === erx, {tag, " R5 R6 rx_data"}, rx_data, erx);
        chk(done_cnt == 1 && done_long == 0, {tag, " R9 single done"}, done_cnt, 1);
        chk(!busy && cs_n && !sclk, {tag, " R9 idle after done"}, {busy, cs_n, sclk}, 3'b010);
        if (total > 0) begin
            chk(first_rise_cyc - cs_fall_cyc == k_div + 1, {tag, " R8 lead time"},
                first_rise_cyc - cs_fall_cyc, k_div + 1);
            chk(cs_rise_cyc - last_fall_cyc == k_div + 1, {tag, " R8 trail time"},
                cs_rise_cyc - last_fall_cyc, k_div + 1);
            chk(cs_bad == 0, {tag, " R8 cs low at each rise"}, cs_bad, 0);
            chk(half_bad == 0, {tag, " R7 half period"}, half_bad, 0);
        end
    endtask

    task automatic clear_cfg();
        k_div = 1; k_ce = 0; k_ae = 0; k_de = 0; k_te = 0; k_re = 0; k_fd = 0;
        k_cl = 0; k_al = 0; k_dl = 0; k_tl = 0; k_rl = 0;
        k_cmd = '0; k_addr = '0; k_tx = '0;
    endtask

    task automatic t_reset();
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0 && mosi === 1'b0,
            "R9 reset state", {cs_n, sclk, busy, done, mosi}, 5'b10000);
    endtask

    task automatic t_cmd_addr_tx();
        clear_cfg();
        k_ce = 1; k_cl = 8; k_cmd = 16'h12A5;
        k_ae = 1; k_al = 24; k_addr = 32'hFF3C_5A96;
        k_te = 1; k_tl = 16; k_tx = 512'hBEEF_C0DE;
        run_txn("R2 R3 cmd+addr+tx", 0);
    endtask

    task automatic t_half_duplex();
        clear_cfg();
        k_div = 2;
        k_ce = 1; k_cl = 5; k_cmd = 16'h0013;
        k_de = 1; k_dl = 3;
        k_te = 1; k_tl = 8; k_tx = 512'h00C3;
        k_re = 1; k_rl = 12;
        run_txn("R4 R5 half duplex", 0);
    endtask

    task automatic t_full_duplex();
        clear_cfg();
        k_fd = 1;
        k_ae = 1; k_al = 7; k_addr = 32'h55;
        k_te = 1; k_tl = 20; k_tx = 512'hF_0F0F;
        k_re = 1; k_rl = 10;
        run_txn("R6 full duplex tx longer", 0);
        clear_cfg();
        k_fd = 1;
        k_te = 1; k_tl = 4; k_tx = 512'hD;
        k_re = 1; k_rl = 13;
        run_txn("R6 full duplex rx longer", 0);
    endtask

    task automatic t_disabled_skip();
        clear_cfg();
        k_ce = 0; k_cl = 8; k_cmd = 16'hFFFF;
        k_ae = 1; k_al = 0; k_addr = 32'hFFFF_FFFF;
        k_de = 0; k_dl = 40;
        k_te = 1; k_tl = 6; k_tx = 512'h2D;
        k_re = 0; k_rl = 9;
        run_txn("R1 disabled phases skipped", 0);
    endtask

    task automatic t_empty();
        clear_cfg();
        k_ce = 0; k_cl = 16; k_ae = 1; k_al = 0; k_te = 1; k_tl = 0;
        @(negedge clk);
        rise_cnt = 0; done_cnt = 0;
        apply_cfg();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && cs_n === 1'b1 && busy === 1'b0, "R11 empty done next cycle",
            {done, cs_n, busy}, 3'b110);
        repeat (6) @(negedge clk);
        chk(rise_cnt == 0 && done_cnt == 1, "R11 empty no clock", rise_cnt, 0);
    endtask

    task automatic t_start_busy();
        clear_cfg();
        k_div = 1;
        k_ce = 1; k_cl = 12; k_cmd = 16'h0A5C;
        k_te = 1; k_tl = 24; k_tx = 512'h93_6C1E;
        run_txn("R10 start while busy ignored", 1);
    endtask

    task automatic t_max();
        clear_cfg();
        k_div = 0; k_fd = 1;
        k_ce = 1; k_cl = 16; k_cmd = 16'hC35A;
        k_ae = 1; k_al = 32; k_addr = 32'h8765_4321;
        k_de = 1; k_dl = 256;
        k_te = 1; k_tl = 512;
        for (int i = 0; i < DATA_W; i++) k_tx[i] = pat[(i * 5 + 11) % MAXB] ^ i[0];
        k_re = 1; k_rl = 512;
        run_txn("R4 R6 maximum lengths", 0);
    endtask

    task automatic t_slow_div();
        clear_cfg();
        k_div = 3;
        k_ae = 1; k_al = 32; k_addr = 32'h8000_0001;
        k_re = 1; k_rl = 5;
        run_txn("R7 R8 slow divider", 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int i = 0; i < MAXB; i++) begin
            pat[i] = lfsr[0];
            rec[i] = 1'b0;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        clear_cfg();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_addr_tx();
        t_half_duplex();
        t_full_duplex();
        t_disabled_skip();
        t_empty();
        t_start_busy();
        t_max();
        t_slow_div();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 150000);
        failures = failures + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule